// File: doc/BRIEF.md
# Dual-Select Static RAM Core

A clocked model of a word-wide static memory that shares one data bus for reads and writes. Two chip selects of opposite polarity, an active-low write enable and an active-low output enable are decoded every clock into one of four modes: power-down, output-disable, read and write. The bidirectional bus is split into a data-in port, a data-out port and a drive-enable flag. A pad ring or a bus model combines them into a tri-state pin.

The strobes are sampled on each rising clock edge. A write window is open in every cycle in which both selects are active and the write enable is low. The address is captured in the cycle in which the window opens. The data word is taken in the cycle in which the window closes, and it is committed at that edge. Write enable wins over output enable, so the bus is never driven while a write is under way. Read data and the drive flag are registered, so they follow the sampled inputs by one clock.

The strobes are level controls, not a stream. For that reason the block has no valid/ready handshake and no back-pressure: every cycle is accepted.

Top module: `sram_dual_sel`

## Requirements
- R1: Storage holds 2**ADDR_W words of DATA_W bits (ADDR_W=13 and DATA_W=8 give the full 8192 x 8 part). Address 0 and address 2**ADDR_W-1 can each be written and read back independently.
- R2: A cycle with cs_n=1 or cs_hi=0 is deselected. After it, dq_oe=0, and no write window is active in it, whatever the values of we_n and oe_n.
- R3: A selected cycle with we_n=1 and oe_n=1 is output-disable. After it, dq_oe=0, and it writes nothing.
- R4: A selected cycle with we_n=1 and oe_n=0 is a read, unless a write is being committed in that cycle. After it, dq_oe=1 and dq_out holds the word stored at that cycle's address.
- R5: A selected cycle with we_n=0 is a write cycle. After it, dq_oe=0, whether oe_n is 0 or 1.
- R6: The write window opens in the first cycle with cs_n=0, cs_hi=1 and we_n=0. The address sampled in that opening cycle is the one written.
- R7: The window closes in the first cycle in which any of the three strobes is inactive. The dq_in word sampled in that closing cycle is stored, and dq_oe=0 after that cycle even if it decodes as a read.
- R8: A read in the cycle after a commit, at the committed address, returns the newly written word.
- R9: Contents are kept unchanged across any number of deselected cycles.
- R10: While rst_n=0 and after it, until the next qualifying cycle, dq_oe=0 and dq_out=0, and no write window is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control state and output registers |
| cs_n | input | 1 | Active-low chip select |
| cs_hi | input | 1 | Active-high chip select |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Word address |
| dq_in | input | DATA_W | Bus value seen by the memory (write data) |
| dq_out | output | DATA_W | Registered read word |
| dq_oe | output | 1 | 1 when the memory drives the bus |

## Verification
The bench builds the block with ADDR_W=8 and DATA_W=8. With only 256 words, random addresses often return to a recently written location, so read-after-commit and overwrite cases happen often rather than rarely. The lowest and highest addresses are also reached directly. Random strobe patterns give windows that close through each of the three strobes, windows of one cycle and of many cycles, and commits followed at once by a read. Directed cases cover deselection with write enable low and retention across long idle spells.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } mode_e;
endpackage

// File: rtl/sram_mode_dec.sv
module sram_mode_dec
  import sram_pkg::*;
(
  input  logic  cs_n,
  input  logic  cs_hi,
  input  logic  we_n,
  input  logic  oe_n,
  output mode_e mode,
  output logic  win
);
  logic sel;
  assign sel = ~cs_n & cs_hi;

  always_comb begin
    if (!sel)      mode = MODE_OFF;
    else if (!we_n) mode = MODE_WRITE;
    else if (!oe_n) mode = MODE_READ;
    else            mode = MODE_IDLE;
  end

  assign win = (mode == MODE_WRITE);
endmodule

// File: rtl/sram_wr_window.sv
module sram_wr_window #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win,
  input  logic [ADDR_W-1:0] addr,
  output logic              commit,
  output logic [ADDR_W-1:0] waddr
);
  logic              win_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      win_q <= win;
      if (win && !win_q) addr_q <= addr;
    end
  end

  assign commit = win_q & ~win;
  assign waddr  = addr_q;
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wen) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mem[raddr];
  end
endmodule

// File: rtl/sram_dual_sel.sv
module sram_dual_sel
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cs_hi,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  mode_e             mode;
  logic              win;
  logic              commit_w;
  logic [ADDR_W-1:0] waddr;

  sram_mode_dec u_dec (
    .cs_n (cs_n),
    .cs_hi(cs_hi),
    .we_n (we_n),
    .oe_n (oe_n),
    .mode (mode),
    .win  (win)
  );

  sram_wr_window #(.ADDR_W(ADDR_W)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .win   (win),
    .addr  (addr),
    .commit(commit_w),
    .waddr (waddr)
  );

  sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk  (clk),
    .rst_n(rst_n),
    .wen  (commit_w),
    .waddr(waddr),
    .wdata(dq_in),
    .raddr(addr),
    .rdata(dq_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dq_oe <= 1'b0;
    else        dq_oe <= (mode == MODE_READ) && !commit_w;
  end
endmodule

// File: rtl/sram_dual_sel_chk.sv
module sram_dual_sel_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic cs_hi,
  input logic we_n,
  input logic oe_n,
  input logic commit,
  input logic dq_oe
);
  // R2
  desel_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !cs_hi) |=> !dq_oe);

  // R3
  idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cs_hi && we_n && oe_n) |=> !dq_oe);

  // R4
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cs_hi && we_n && !oe_n && !commit) |=> dq_oe);

  // R5
  write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cs_hi && !we_n) |=> !dq_oe);

  // R7
  commit_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !dq_oe);

  // R2
  desel_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !cs_hi) |=> !(commit && (cs_n || !cs_hi)));
endmodule

bind sram_dual_sel sram_dual_sel_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cs_n  (cs_n),
  .cs_hi (cs_hi),
  .we_n  (we_n),
  .oe_n  (oe_n),
  .commit(commit_w),
  .dq_oe (dq_oe)
);

// File: tb/sram_dual_sel_bench.sv
`timescale 1ns/1ps
module sram_dual_sel_bench;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1, cs_hi = 1'b0, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [DW-1:0] model [DEPTH];
  bit            m_valid [DEPTH];
  bit            m_winq = 0;
  logic [AW-1:0] m_addr = '0;

  always #5 clk = ~clk;

  sram_dual_sel #(.ADDR_W(AW), .DATA_W(DW)) u_sram_dual_sel (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_hi(cs_hi), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(bit c_n, bit c_hi, bit w_n, bit o_n, bit cm);
    if (c_n || !c_hi) return "R2";
    if (!w_n) return "R5";
    if (cm) return "R7";
    if (o_n) return "R3";
    return "R4";
  endfunction

  task automatic step(bit c_n, bit c_hi, bit w_n, bit o_n,
                      logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    bit sel, win, cm, e_oe, e_valid;
    logic [DW-1:0] e_out;
    @(negedge clk);
    cs_n = c_n; cs_hi = c_hi; we_n = w_n; oe_n = o_n; addr = a; dq_in = d;
    sel = !c_n && c_hi;
    win = sel && !w_n;
    cm = m_winq && !win;
    e_oe = sel && w_n && !o_n && !cm;
    e_out = model[a];
    e_valid = m_valid[a];
    @(posedge clk);
    if (cm) begin
      model[m_addr] = d;
      m_valid[m_addr] = 1;
    end
    if (win && !m_winq) m_addr = a;
    m_winq = win;
    #1;
    chk((tag == "") ? mode_tag(c_n, c_hi, w_n, o_n, cm) : tag, {7'd0, dq_oe}, {7'd0, e_oe});
    if (e_oe && e_valid)
      chk((tag == "") ? "R4" : tag, dq_out, e_out);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < DEPTH; i++) m_valid[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", {7'd0, dq_oe}, 8'd0);
    chk("R10", dq_out, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R6 R7: window closed by we_n
    step(0, 1, 0, 1, 8'd3, 8'h00, "R6");
    step(0, 1, 1, 1, 8'd9, 8'hA5, "R7");
    // R8: read immediately after commit
    step(0, 1, 1, 0, 8'd3, 8'h00, "R8");
    // R1: extremes
    step(0, 1, 0, 1, 8'd0, 8'h00, "R1");
    step(0, 1, 1, 1, 8'd0, 8'h3C, "R1");
    step(0, 1, 0, 1, 8'd255, 8'h00, "R1");
    step(0, 1, 1, 0, 8'd255, 8'hC3, "R7");
    step(0, 1, 1, 0, 8'd0, 8'h00, "R1");
    step(0, 1, 1, 0, 8'd255, 8'h00, "R1");
    // R2: deselected with we low must not write
    step(1, 1, 0, 0, 8'd3, 8'hFF, "R2");
    step(0, 0, 0, 0, 8'd3, 8'hEE, "R2");
    step(1, 0, 0, 1, 8'd3, 8'hDD, "R2");
    // R9: long deselected spell then read back
    for (int i = 0; i < 40; i++) step(1, 0, 1, 0, 8'(i), 8'(i), "R9");
    step(0, 1, 1, 0, 8'd3, 8'h00, "R9");
    // R3: output disable, no write
    step(0, 1, 1, 1, 8'd3, 8'h77, "R3");
    step(0, 1, 1, 0, 8'd3, 8'h00, "R3");
    // R5 R6 R7: oe low fixed, address changes in window, closed by cs_n
    step(0, 1, 0, 0, 8'd5, 8'h11, "R5");
    step(0, 1, 0, 0, 8'd6, 8'h22, "R5");
    step(1, 1, 0, 0, 8'd6, 8'h33, "R7");
    step(0, 1, 1, 0, 8'd6, 8'h00, "R6");
    step(0, 1, 1, 0, 8'd5, 8'h00, "R6");
    // R7: closed by cs_hi while oe low
    step(0, 1, 0, 0, 8'd7, 8'h00, "R5");
    step(0, 0, 0, 0, 8'd7, 8'h5A, "R7");
    step(0, 1, 1, 0, 8'd7, 8'h00, "R8");

    for (int n = 0; n < 4000; n++) begin
      bit c_n, c_hi, w_n, o_n;
      c_n  = ($urandom_range(0, 9) == 0);
      c_hi = ($urandom_range(0, 9) != 0);
      w_n  = ($urandom_range(0, 2) != 0);
      o_n  = ($urandom_range(0, 3) == 0);
      step(c_n, c_hi, w_n, o_n, 8'($urandom_range(0, 15) * 17 % DEPTH),
           8'($urandom), "");
    end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule